// File: doc/BRIEF.md
# Code Memory Programming Controller

This block manages an on-chip byte-wide code store while it is being programmed from outside the chip. Commands arrive one per cycle on a small command port: array read, byte write, whole-array erase, configuration write and configuration read. Each command carries a mode flag that selects parallel or serial programming rules. Writes and erases are self-timed. Their lengths are cycle counts set by parameters, so the nominal 1.5 ms byte write and the 16 ms serial erase scale with the clock.

While an operation runs, `ready` stays low. A read of the byte that is being written returns the new value with its top bit inverted, which gives the host a way to poll for completion. Two lock bits block array reads when both are set. A serial-enable fuse can only be changed through parallel commands. When the fuse is cleared, every serial command is dropped without any response. A finished chip erase sets every byte to 0xFF and clears both lock bits.

The store is a register array of `MEM_BYTES` bytes. A default of 3072 keeps the model small. Setting it to 12288 covers the full 0x0000 to 0x2FFF code space.

Top module: `flash_prog_ctrl`

## Requirements
- R1: After reset every byte reads 0xFF, `ready` is high, both lock bits are clear and the serial-enable fuse is set, so a parallel configuration read returns 0x80.
- R2: Addresses at or above `MEM_BYTES` are out of range. A read or write there raises `cmd_err` and changes no state. The last valid address behaves like any other valid address.
- R3: An accepted byte write drives `ready` low for exactly `WRITE_CYC` cycles, starting in the cycle after the command, and then commits the byte.
- R4: While a write is busy, a read of its address returns the value being written with bit 7 inverted. Once `ready` is high again, the same read returns the true value.
- R5: A serial-mode write replaces the byte with the new data. A parallel-mode write stores the old byte AND the new data.
- R6: A serial chip erase holds `ready` low for `ERASE_SER_CYC` cycles, then sets every byte to 0xFF and clears both lock bits. Any read issued during it returns 0x00.
- R7: A parallel chip erase is accepted only while `erase_strobe_n` is low. It completes after `ERASE_PAR_CYC` cycles of the strobe held low. Releasing the strobe early ends the operation with no change. A read issued during it raises `cmd_err`.
- R8: A configuration write ORs `cmd_wdata[0]` into lock bit A and `cmd_wdata[1]` into lock bit B. While both lock bits are set, array reads raise `cmd_err`. With only one set, array reads still return data.
- R9: A parallel configuration read returns {fuse, 5'b0, lockB, lockA}. A serial configuration read raises `cmd_err`.
- R10: A parallel configuration write loads the fuse from `cmd_wdata[7]`, where 1 means enabled. A serial configuration write leaves the fuse unchanged. While the fuse is clear, serial commands produce no response and have no effect.
- R11: While `ready` is low, any command other than an array read raises `cmd_err` and has no effect.
- R12: The opcodes are 0 read, 1 write, 2 chip erase, 3 configuration write and 4 configuration read, and `cmd_serial`=1 selects serial mode. `rd_valid` and `cmd_err` are single-cycle pulses that appear in the cycle after the command and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Opcode |
| cmd_serial | input | 1 | 1 selects serial-mode rules |
| cmd_addr | input | ADDR_W | Byte address |
| cmd_wdata | input | 8 | Write data or configuration bits |
| erase_strobe_n | input | 1 | Parallel erase strobe, active low |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 8 | Read result |
| cmd_err | output | 1 | Rejected-command pulse |
| ready | output | 1 | High when no write or erase is running |

## Verification
Every read response and every rejection is registered, so the bench drives each command on a falling edge and samples `rd_valid`, `rd_data` and `cmd_err` on the next falling edge. The low phase of `ready` starts on that same sample. The bench then counts it edge by edge: `WRITE_CYC`, `ERASE_SER_CYC` or `ERASE_PAR_CYC` falling edges low, followed by the first high sample. A polling read placed inside that window uses two of the counted edges, and the bench subtracts them from the remaining low count. Array contents after each commit are checked against a bench model that applies the replace or AND rule.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

   typedef enum logic [2:0] {
      OP_READ   = 3'd0,
      OP_WRITE  = 3'd1,
      OP_ERASE  = 3'd2,
      OP_CFG_WR = 3'd3,
      OP_CFG_RD = 3'd4
   } op_e;

   typedef enum logic [1:0] {
      JOB_NONE      = 2'd0,
      JOB_WRITE     = 2'd1,
      JOB_ERASE_SER = 2'd2,
      JOB_ERASE_PAR = 2'd3
   } job_e;

   typedef enum logic [3:0] {
      ACT_NONE,
      ACT_ERR,
      ACT_RD_ARRAY,
      ACT_RD_POLL,
      ACT_RD_ZERO,
      ACT_RD_CFG,
      ACT_WRITE,
      ACT_ERASE,
      ACT_CFG_WR
   } act_e;

   localparam logic [7:0] BLANK_BYTE = 8'hFF;
   localparam logic [7:0] POLL_FLIP  = 8'h80;

endpackage

// File: rtl/fpc_timer.sv
module fpc_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] load_val,
   input  logic             hold,
   output logic             busy,
   output logic             done,
   output logic             abort
);

   logic [CNT_W-1:0] cnt;

   assign done  = busy && hold && (cnt == CNT_W'(1));
   assign abort = busy && !hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (start) begin
         busy <= 1'b1;
         cnt  <= load_val;
      end else if (busy) begin
         if (!hold || cnt == CNT_W'(1)) begin
            busy <= 1'b0;
            cnt  <= '0;
         end else begin
            cnt <= cnt - CNT_W'(1);
         end
      end
   end

   // a running count never reaches zero before it ends
   p_cnt_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> cnt != '0);

   // a released strobe ends the operation on the next edge
   p_abort_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (abort && !start) |=> !busy);

endmodule

// File: rtl/fpc_array.sv
module fpc_array
   import fpc_pkg::*;
#(
   parameter int MEM_BYTES = 256,
   parameter int IDX_W     = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [7:0]       wr_data,
   input  logic             erase_all,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [7:0]       rd_data
);

   logic [7:0] byte_q [MEM_BYTES];

   for (genvar g = 0; g < MEM_BYTES; g++) begin : g_byte
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= BLANK_BYTE;
         else if (erase_all)
            q <= BLANK_BYTE;
         else if (wr_en && wr_idx == IDX_W'(g))
            q <= wr_data;
      end
      assign byte_q[g] = q;
   end

   if (MEM_BYTES == (1 << IDX_W)) begin : g_full_decode
      assign rd_data = byte_q[rd_idx];
   end else begin : g_guarded_decode
      assign rd_data = (int'(rd_idx) < MEM_BYTES) ? byte_q[rd_idx] : BLANK_BYTE;
   end

   p_erase_write_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(erase_all && wr_en));

endmodule

// File: rtl/fpc_decode.sv
module fpc_decode
   import fpc_pkg::*;
#(
   parameter int ADDR_W    = 14,
   parameter int MEM_BYTES = 256
) (
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic              cmd_serial,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic              busy,
   input  job_e              job,
   input  logic              fuse_en,
   input  logic              locked,
   input  logic [ADDR_W-1:0] last_addr,
   input  logic              erase_strobe_n,
   output act_e              act
);

   localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(MEM_BYTES);

   logic in_range;
   assign in_range = {1'b0, cmd_addr} < LIMIT;

   always_comb begin
      act = ACT_NONE;
      if (cmd_valid && !(cmd_serial && !fuse_en)) begin
         case (cmd_op)
            OP_READ: begin
               if (busy && job == JOB_ERASE_SER)                   act = ACT_RD_ZERO;
               else if (busy && job == JOB_ERASE_PAR)              act = ACT_ERR;
               else if (!in_range)                                 act = ACT_ERR;
               else if (locked)                                    act = ACT_ERR;
               else if (busy && job == JOB_WRITE && cmd_addr == last_addr)
                                                                   act = ACT_RD_POLL;
               else                                                act = ACT_RD_ARRAY;
            end
            OP_WRITE: begin
               if (busy || !in_range) act = ACT_ERR;
               else                   act = ACT_WRITE;
            end
            OP_ERASE: begin
               if (busy)                             act = ACT_ERR;
               else if (!cmd_serial && erase_strobe_n) act = ACT_ERR;
               else                                  act = ACT_ERASE;
            end
            OP_CFG_WR: begin
               if (busy) act = ACT_ERR;
               else      act = ACT_CFG_WR;
            end
            OP_CFG_RD: begin
               if (busy || cmd_serial) act = ACT_ERR;
               else                    act = ACT_RD_CFG;
            end
            default: act = ACT_ERR;
         endcase
      end
   end

endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
   import fpc_pkg::*;
#(
   parameter int MEM_BYTES     = 3072,
   parameter int ADDR_W        = 14,
   parameter int WRITE_CYC     = 75000,
   parameter int ERASE_SER_CYC = 800000,
   parameter int ERASE_PAR_CYC = 500000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic              cmd_serial,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [7:0]        cmd_wdata,
   input  logic              erase_strobe_n,
   output logic              rd_valid,
   output logic [7:0]        rd_data,
   output logic              cmd_err,
   output logic              ready
);

   localparam int IDX_W   = $clog2(MEM_BYTES);
   localparam int MAX_ER  = (ERASE_SER_CYC > ERASE_PAR_CYC) ? ERASE_SER_CYC : ERASE_PAR_CYC;
   localparam int MAX_CYC = (WRITE_CYC > MAX_ER) ? WRITE_CYC : MAX_ER;
   localparam int CNT_W   = $clog2(MAX_CYC + 1);

   if (MEM_BYTES < 2 || MEM_BYTES > (1 << ADDR_W)) begin : g_bad_depth
      $error("MEM_BYTES must lie in 2 .. 2**ADDR_W");
   end
   if (WRITE_CYC < 1 || ERASE_SER_CYC < 1 || ERASE_PAR_CYC < 1) begin : g_bad_timing
      $error("cycle counts must be at least 1");
   end

   logic              busy, done, abort, hold, start;
   logic              wr_en, erase_all;
   logic [CNT_W-1:0]  load_val;
   job_e              job;
   act_e              act;
   logic [ADDR_W-1:0] last_addr;
   logic [7:0]        last_val;
   logic [7:0]        arr_rd;
   logic              lock_a, lock_b, fuse_en, locked;

   assign locked    = lock_a && lock_b;
   assign ready     = !busy;
   assign start     = (act == ACT_WRITE) || (act == ACT_ERASE);
   assign load_val  = (act == ACT_WRITE) ? CNT_W'(WRITE_CYC)
                    : (cmd_serial ? CNT_W'(ERASE_SER_CYC) : CNT_W'(ERASE_PAR_CYC));
   assign hold      = (job == JOB_ERASE_PAR) ? !erase_strobe_n : 1'b1;
   assign wr_en     = done && (job == JOB_WRITE);
   assign erase_all = done && (job == JOB_ERASE_SER || job == JOB_ERASE_PAR);

   fpc_decode #(.ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES)) u_decode (
      .cmd_valid      (cmd_valid),
      .cmd_op         (cmd_op),
      .cmd_serial     (cmd_serial),
      .cmd_addr       (cmd_addr),
      .busy           (busy),
      .job            (job),
      .fuse_en        (fuse_en),
      .locked         (locked),
      .last_addr      (last_addr),
      .erase_strobe_n (erase_strobe_n),
      .act            (act)
   );

   fpc_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .load_val (load_val),
      .hold     (hold),
      .busy     (busy),
      .done     (done),
      .abort    (abort)
   );

   fpc_array #(.MEM_BYTES(MEM_BYTES), .IDX_W(IDX_W)) u_array (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_idx    (last_addr[IDX_W-1:0]),
      .wr_data   (last_val),
      .erase_all (erase_all),
      .rd_idx    (cmd_addr[IDX_W-1:0]),
      .rd_data   (arr_rd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid  <= 1'b0;
         rd_data   <= '0;
         cmd_err   <= 1'b0;
         job       <= JOB_NONE;
         last_addr <= '0;
         last_val  <= BLANK_BYTE;
         lock_a    <= 1'b0;
         lock_b    <= 1'b0;
         fuse_en   <= 1'b1;
      end else begin
         rd_valid <= 1'b0;
         cmd_err  <= 1'b0;
         if (erase_all) begin
            lock_a <= 1'b0;
            lock_b <= 1'b0;
         end
         case (act)
            ACT_ERR:      cmd_err <= 1'b1;
            ACT_RD_ARRAY: begin rd_valid <= 1'b1; rd_data <= arr_rd; end
            ACT_RD_POLL:  begin rd_valid <= 1'b1; rd_data <= last_val ^ POLL_FLIP; end
            ACT_RD_ZERO:  begin rd_valid <= 1'b1; rd_data <= 8'h00; end
            ACT_RD_CFG:   begin rd_valid <= 1'b1; rd_data <= {fuse_en, 5'b0, lock_b, lock_a}; end
            ACT_WRITE: begin
               job       <= JOB_WRITE;
               last_addr <= cmd_addr;
               last_val  <= cmd_serial ? cmd_wdata : (arr_rd & cmd_wdata);
            end
            ACT_ERASE:    job <= cmd_serial ? JOB_ERASE_SER : JOB_ERASE_PAR;
            ACT_CFG_WR: begin
               lock_a <= lock_a | cmd_wdata[0];
               lock_b <= lock_b | cmd_wdata[1];
               if (!cmd_serial) fuse_en <= cmd_wdata[7];
            end
            default: ;
         endcase
      end
   end

   p_resp_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_valid && cmd_err));

   p_resp_follows_cmd_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid || cmd_err) |-> $past(cmd_valid));

   p_busy_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ready) |-> $past(cmd_valid));

   p_busy_reject_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !ready && (!cmd_serial || fuse_en) && cmd_op == OP_WRITE) |=> cmd_err);

   p_lock_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_READ && locked && ready) |=> !rd_valid);

   p_erase_unlocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
      erase_all |=> (!lock_a && !lock_b));

   p_fuse_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_serial && !fuse_en) |=> (!rd_valid && !cmd_err));

endmodule

// File: tb/flash_prog_ctrl_tb_top.sv
module flash_prog_ctrl_tb_top;

   localparam int MB = 256;
   localparam int W  = 8;
   localparam int ES = 12;
   localparam int EP = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [2:0]  cmd_op = '0;
   logic        cmd_serial = 1'b0;
   logic [13:0] cmd_addr = '0;
   logic [7:0]  cmd_wdata = '0;
   logic        erase_strobe_n = 1'b1;
   logic        rd_valid, cmd_err, ready;
   logic [7:0]  rd_data;

   int n_checks = 0;
   int n_err    = 0;
   logic [7:0] model [MB];

   always #10 clk = ~clk;

   flash_prog_ctrl #(.MEM_BYTES(MB), .ADDR_W(14), .WRITE_CYC(W),
                     .ERASE_SER_CYC(ES), .ERASE_PAR_CYC(EP)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_serial(cmd_serial), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
      .erase_strobe_n(erase_strobe_n), .rd_valid(rd_valid), .rd_data(rd_data),
      .cmd_err(cmd_err), .ready(ready));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] next_val(input logic [7:0] old, input logic [7:0] d,
                                           input logic ser);
      return ser ? d : (old & d);
   endfunction

   task automatic issue(input logic [2:0] op, input logic ser, input int addr, input logic [7:0] d);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_serial = ser;
      cmd_addr = 14'(addr); cmd_wdata = d;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic exp_data(input string req, input logic [7:0] v);
      check({req, " valid"}, {31'b0, rd_valid}, 1);
      check({req, " err"}, {31'b0, cmd_err}, 0);
      check({req, " data"}, {24'b0, rd_data}, {24'b0, v});
   endtask

   task automatic exp_err(input string req);
      check({req, " err"}, {31'b0, cmd_err}, 1);
      check({req, " valid"}, {31'b0, rd_valid}, 0);
   endtask

   task automatic exp_silent(input string req);
      check({req, " err"}, {31'b0, cmd_err}, 0);
      check({req, " valid"}, {31'b0, rd_valid}, 0);
   endtask

   task automatic finish_busy(input string req, input int low_left);
      for (int i = 0; i < low_left; i++) begin
         @(negedge clk);
         check({req, " busy"}, {31'b0, ready}, 0);
      end
      @(negedge clk);
      check({req, " ready"}, {31'b0, ready}, 1);
   endtask

   task automatic do_write(input logic ser, input int addr, input logic [7:0] d);
      issue(3'd1, ser, addr, d);
      if (addr >= MB) begin
         exp_err("R2 write range");
         check("R2 no busy", {31'b0, ready}, 1);
      end else begin
         check("R3 busy start", {31'b0, ready}, 0);
         finish_busy("R3", W - 1);
         model[addr] = next_val(model[addr], d, ser);
      end
   endtask

   task automatic do_read(input logic ser, input int addr, input string req);
      issue(3'd0, ser, addr, 8'h00);
      if (addr >= MB) exp_err({req, " R2 range"});
      else exp_data(req, model[addr]);
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=done");
      summary();
      $finish;
   end

   initial begin
      for (int i = 0; i < MB; i++) model[i] = 8'hFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 ready", {31'b0, ready}, 1);
      exp_silent("R1 idle");
      do_read(1'b0, 0, "R1 byte0");
      do_read(1'b1, MB - 1, "R1 top byte");
      issue(3'd4, 1'b0, 0, 8'h00);
      exp_data("R1 cfg", 8'h80);

      // R2 range boundary
      do_read(1'b0, MB, "R2 first bad");
      do_write(1'b0, MB + 5, 8'h00);
      do_write(1'b1, MB - 1, 8'h3C);
      do_read(1'b0, MB - 1, "R2 last good");

      // R4 polling and R3 timing
      issue(3'd1, 1'b1, 17, 8'h5A);
      check("R3 busy start", {31'b0, ready}, 0);
      issue(3'd0, 1'b0, 17, 8'h00);
      exp_data("R4 poll", 8'hDA);
      finish_busy("R3", W - 3);
      model[17] = 8'h5A;
      do_read(1'b0, 17, "R4 true after");

      // R5 parallel AND, serial replace
      do_write(1'b0, 17, 8'h0F);
      do_read(1'b0, 17, "R5 and");
      check("R5 and model", {24'b0, model[17]}, 32'h0A);
      do_write(1'b1, 17, 8'hF0);
      do_read(1'b1, 17, "R5 replace");

      // R11 rejection while busy
      issue(3'd1, 1'b0, 40, 8'h11);
      issue(3'd1, 1'b0, 41, 8'h00);
      exp_err("R11 write while busy");
      issue(3'd2, 1'b1, 0, 8'h00);
      exp_err("R11 erase while busy");
      finish_busy("R11", W - 5);
      model[40] = 8'h11;
      do_read(1'b0, 41, "R11 untouched");
      do_read(1'b0, 40, "R11 first ok");

      // R8 lock bits, R9 config read
      issue(3'd3, 1'b0, 0, 8'h81);
      exp_silent("R8 cfg write");
      do_read(1'b0, 40, "R8 one lock");
      issue(3'd3, 1'b1, 0, 8'h02);
      issue(3'd0, 1'b0, 40, 8'h00);
      exp_err("R8 locked read");
      issue(3'd4, 1'b0, 0, 8'h00);
      exp_data("R9 cfg locks", 8'h83);
      issue(3'd4, 1'b1, 0, 8'h00);
      exp_err("R9 serial cfg read");

      // R6 serial erase
      issue(3'd2, 1'b1, 0, 8'h00);
      check("R6 busy start", {31'b0, ready}, 0);
      issue(3'd0, 1'b1, 40, 8'h00);
      exp_data("R6 read zero", 8'h00);
      finish_busy("R6", ES - 3);
      for (int i = 0; i < MB; i++) model[i] = 8'hFF;
      do_read(1'b0, 40, "R6 blank");
      do_read(1'b0, MB - 1, "R6 blank top");
      issue(3'd4, 1'b0, 0, 8'h00);
      exp_data("R6 locks cleared", 8'h80);

      // R7 parallel erase: strobe needed, abort, full
      do_write(1'b1, 9, 8'h21);
      issue(3'd2, 1'b0, 0, 8'h00);
      exp_err("R7 strobe high");
      erase_strobe_n = 1'b0;
      issue(3'd2, 1'b0, 0, 8'h00);
      check("R7 busy start", {31'b0, ready}, 0);
      @(negedge clk);
      erase_strobe_n = 1'b1;
      @(negedge clk);
      check("R7 abort ready", {31'b0, ready}, 1);
      do_read(1'b0, 9, "R7 abort no change");
      erase_strobe_n = 1'b0;
      issue(3'd2, 1'b0, 0, 8'h00);
      check("R7 busy start", {31'b0, ready}, 0);
      issue(3'd0, 1'b0, 9, 8'h00);
      exp_err("R7 read during erase");
      finish_busy("R7", EP - 3);
      erase_strobe_n = 1'b1;
      model[9] = 8'hFF;
      do_read(1'b0, 9, "R7 erased");

      // R10 fuse
      issue(3'd3, 1'b0, 0, 8'h00);
      issue(3'd0, 1'b1, 9, 8'h00);
      exp_silent("R10 serial read dropped");
      issue(3'd1, 1'b1, 9, 8'h00);
      exp_silent("R10 serial write dropped");
      check("R10 no busy", {31'b0, ready}, 1);
      issue(3'd3, 1'b1, 0, 8'h80);
      exp_silent("R10 serial cfg dropped");
      do_read(1'b0, 9, "R10 unchanged");
      issue(3'd4, 1'b0, 0, 8'h00);
      exp_data("R10 fuse off", 8'h00);
      issue(3'd3, 1'b0, 0, 8'h80);
      issue(3'd3, 1'b1, 0, 8'h00);
      issue(3'd4, 1'b0, 0, 8'h00);
      exp_data("R10 fuse on kept", 8'h80);

      // R12 bad opcode
      issue(3'd6, 1'b0, 0, 8'h00);
      exp_err("R12 bad op");

      // random mix, R2 R5 R12
      void'($urandom(32'h1F0C5EED));
      for (int k = 0; k < 150; k++) begin
         int a;
         logic s;
         a = int'($urandom_range(MB + 7, 0));
         s = 1'($urandom_range(1, 0));
         if ($urandom_range(1, 0) == 0) do_write(s, a, 8'($urandom()));
         else do_read(s, a, "R5 random read");
      end

      summary();
      $finish;
   end

endmodule